// File: doc/BRIEF.md
# Nibble-Wide BCD Calendar Clock

This block keeps time of day and calendar date as a set of independent 4-bit BCD digit registers. The smallest digit counts tenths of a second. A one-cycle timebase pulse at 10 Hz advances it, and each digit carries into the next one as it rolls over. The chain climbs through seconds, minutes and hours to day of month and month. A day-of-week counter runs alongside the day digits.

The number of days in each month is worked out in hardware from the month digits. February length comes from a 2-bit leap-year phase counter, which steps once at every year boundary. Software never has to correct the date.

A processor reaches the block through a narrow register port. A 4-bit index selects one digit and a 4-bit data bus carries it. Writes happen on a clock edge. Reads are combinational from the selected register.

Top module: `bcd_calendar_clock`

## Requirements
- R1: An active-low reset loads 00:00:00.0, day 01, month 01, day of week 0 and leap phase 0.
- R2: The register index selects the digit as follows: 0 tenths, 1 second units, 2 second tens, 3 minute units, 4 minute tens, 5 hour units, 6 hour tens, 7 day units, 8 day tens, 9 day of week, 10 month units, 11 month tens, 12 leap phase. A write stores wr_data into the indexed register on the clock edge. rd_data shows the indexed register combinationally.
- R3: Each cycle with tick high advances the tenths digit from 9 to 0 with a carry out. With tick low and no write, every register holds its value.
- R4: Seconds and minutes each count in BCD from 00 to 59. Going from 59 to 00 carries into the next field.
- R5: Hours count from 00 to 23. Units roll from 9 to 0 into the tens digit. Going from 23 to 00 carries into the day.
- R6: The day counts from 01 up to the length of the month, then returns to 01 and carries into the month. Months 4, 6, 9 and 11 have 30 days, and months 1, 3, 5, 7, 8, 10 and 12 have 31.
- R7: February has 29 days when the leap phase is 0 and 28 days otherwise.
- R8: Months count from 01 to 12. Going from 12 to 01 increments the leap phase modulo 4.
- R9: The day of week counts 0 to 6 and advances once on every day rollover, wrapping from 6 to 0.
- R10: A write to a digit takes priority over a tick update of that same digit in the same cycle. All other digits still take their tick update, including carries computed from the old value of the written digit.
- R11: Indices 13 to 15 read as 0, and writes to them change no register.
- R12: The leap phase register at index 12 takes wr_data[1:0] on a write. It reads back in rd_data[1:0], with rd_data[3:2] equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle 10 Hz timebase pulse |
| wr_en | input | 1 | Write strobe for the indexed register |
| addr | input | 4 | Register index for reads and writes |
| wr_data | input | 4 | Digit to write |
| rd_data | output | 4 | Digit read from the indexed register |

## Verification
The hardest conditions to reach are the rarely occurring rollovers: month end for each month length, February in leap and non-leap phases, and the year boundary that steps the leap phase. At one tick per tenth of a second these lie millions of cycles away. The stimulus reaches them by writing the whole time and date to a tenth of a second before the boundary and then giving a single tick. It also drives a write into a digit in the same cycle as a carry into that digit, to check the override. A behavioural model with integer fields follows every cycle and checks the indexed digit.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int DIG_W    = 4;
    localparam int LP_W     = 2;
    localparam int ADDR_W   = 4;
    localparam int N_TIME   = 5;   // tenths, sec units/tens, min units/tens

    typedef logic [DIG_W-1:0]  digit_t;
    typedef logic [ADDR_W-1:0] idx_t;

    localparam idx_t IDX_TENTHS = 4'd0;
    localparam idx_t IDX_SEC_U  = 4'd1;
    localparam idx_t IDX_SEC_T  = 4'd2;
    localparam idx_t IDX_MIN_U  = 4'd3;
    localparam idx_t IDX_MIN_T  = 4'd4;
    localparam idx_t IDX_HR_U   = 4'd5;
    localparam idx_t IDX_HR_T   = 4'd6;
    localparam idx_t IDX_DAY_U  = 4'd7;
    localparam idx_t IDX_DAY_T  = 4'd8;
    localparam idx_t IDX_DOW    = 4'd9;
    localparam idx_t IDX_MON_U  = 4'd10;
    localparam idx_t IDX_MON_T  = 4'd11;
    localparam idx_t IDX_LEAP   = 4'd12;

    localparam digit_t DOW_LAST = 4'd6;

    typedef struct packed {
        digit_t            tenths;
        digit_t            sec_u;
        digit_t            sec_t;
        digit_t            min_u;
        digit_t            min_t;
        digit_t            hr_u;
        digit_t            hr_t;
        digit_t            day_u;
        digit_t            day_t;
        digit_t            dow;
        digit_t            mon_u;
        digit_t            mon_t;
        logic [LP_W-1:0]   leap;
    } cal_state_t;

    // Last value of each digit in the seconds/minutes chain.
    function automatic digit_t time_last(input int i);
        return (i == 2 || i == 4) ? digit_t'(5) : digit_t'(9);
    endfunction
endpackage

// File: rtl/cal_digit_step.sv
module cal_digit_step
    import cal_pkg::*;
#(
    parameter digit_t LAST = 4'd9
) (
    input  digit_t cur,
    input  logic   carry_in,
    output digit_t nxt,
    output logic   carry_out
);
    logic at_top;
    always_comb begin
        at_top    = (cur >= LAST);
        carry_out = carry_in && at_top;
        if (!carry_in)   nxt = cur;
        else if (at_top) nxt = '0;
        else             nxt = cur + digit_t'(1);
    end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  digit_t          mon_u,
    input  digit_t          mon_t,
    input  logic [LP_W-1:0] leap,
    output digit_t          last_u,
    output digit_t          last_t
);
    logic [7:0] mon_bcd;
    always_comb begin
        mon_bcd = {mon_t, mon_u};
        unique case (mon_bcd)
            8'h02: begin
                last_t = 4'd2;
                last_u = (leap == '0) ? 4'd9 : 4'd8;
            end
            8'h04, 8'h06, 8'h09, 8'h11: begin
                last_t = 4'd3;
                last_u = 4'd0;
            end
            default: begin
                last_t = 4'd3;
                last_u = 4'd1;
            end
        endcase
    end
endmodule

// File: rtl/cal_read_mux.sv
module cal_read_mux
    import cal_pkg::*;
(
    input  cal_state_t st,
    input  idx_t       addr,
    output digit_t     rd_data
);
    always_comb begin
        unique case (addr)
            IDX_TENTHS: rd_data = st.tenths;
            IDX_SEC_U:  rd_data = st.sec_u;
            IDX_SEC_T:  rd_data = st.sec_t;
            IDX_MIN_U:  rd_data = st.min_u;
            IDX_MIN_T:  rd_data = st.min_t;
            IDX_HR_U:   rd_data = st.hr_u;
            IDX_HR_T:   rd_data = st.hr_t;
            IDX_DAY_U:  rd_data = st.day_u;
            IDX_DAY_T:  rd_data = st.day_t;
            IDX_DOW:    rd_data = st.dow;
            IDX_MON_U:  rd_data = st.mon_u;
            IDX_MON_T:  rd_data = st.mon_t;
            IDX_LEAP:   rd_data = digit_t'(st.leap);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [3:0] wr_data,
    output logic [3:0] rd_data
);
    cal_state_t state_q, state_d;

    // Seconds/minutes chain built from identical digit steppers.
    digit_t           tm_q [N_TIME];
    digit_t           tm_d [N_TIME];
    logic [N_TIME:0]  tm_c;

    assign tm_q[0] = state_q.tenths;
    assign tm_q[1] = state_q.sec_u;
    assign tm_q[2] = state_q.sec_t;
    assign tm_q[3] = state_q.min_u;
    assign tm_q[4] = state_q.min_t;
    assign tm_c[0] = tick;

    for (genvar i = 0; i < N_TIME; i++) begin : g_time
        cal_digit_step #(.LAST(time_last(i))) u_step (
            .cur       (tm_q[i]),
            .carry_in  (tm_c[i]),
            .nxt       (tm_d[i]),
            .carry_out (tm_c[i+1])
        );
    end

    digit_t last_u, last_t;
    cal_month_len u_mlen (
        .mon_u  (state_q.mon_u),
        .mon_t  (state_q.mon_t),
        .leap   (state_q.leap),
        .last_u (last_u),
        .last_t (last_t)
    );

    cal_read_mux u_rd (
        .st      (state_q),
        .addr    (addr),
        .rd_data (rd_data)
    );

    logic hr_in, hr_wrap, day_in, day_wrap, mon_in, mon_wrap;

    always_comb begin
        state_d = state_q;

        state_d.tenths = tm_d[0];
        state_d.sec_u  = tm_d[1];
        state_d.sec_t  = tm_d[2];
        state_d.min_u  = tm_d[3];
        state_d.min_t  = tm_d[4];

        // Hours 00..23
        hr_in   = tm_c[N_TIME];
        hr_wrap = (state_q.hr_t > 4'd2) ||
                  (state_q.hr_t == 4'd2 && state_q.hr_u >= 4'd3);
        day_in  = hr_in && hr_wrap;
        if (hr_in) begin
            if (hr_wrap) begin
                state_d.hr_u = '0;
                state_d.hr_t = '0;
            end else if (state_q.hr_u >= 4'd9) begin
                state_d.hr_u = '0;
                state_d.hr_t = state_q.hr_t + digit_t'(1);
            end else begin
                state_d.hr_u = state_q.hr_u + digit_t'(1);
            end
        end

        // Day of month 01..length, day of week 0..6
        day_wrap = day_in && ({state_q.day_t, state_q.day_u} >= {last_t, last_u});
        mon_in   = day_wrap;
        if (day_in) begin
            if (day_wrap) begin
                state_d.day_u = 4'd1;
                state_d.day_t = '0;
            end else if (state_q.day_u >= 4'd9) begin
                state_d.day_u = '0;
                state_d.day_t = state_q.day_t + digit_t'(1);
            end else begin
                state_d.day_u = state_q.day_u + digit_t'(1);
            end
            state_d.dow = (state_q.dow >= DOW_LAST) ? '0 : state_q.dow + digit_t'(1);
        end

        // Month 01..12, leap phase on year boundary
        mon_wrap = mon_in && ({state_q.mon_t, state_q.mon_u} >= 8'h12);
        if (mon_in) begin
            if (mon_wrap) begin
                state_d.mon_u = 4'd1;
                state_d.mon_t = '0;
                state_d.leap  = state_q.leap + 1'b1;
            end else if (state_q.mon_u >= 4'd9) begin
                state_d.mon_u = '0;
                state_d.mon_t = state_q.mon_t + digit_t'(1);
            end else begin
                state_d.mon_u = state_q.mon_u + digit_t'(1);
            end
        end

        // Processor write overrides the tick result of the addressed digit.
        if (wr_en) begin
            unique case (addr)
                IDX_TENTHS: state_d.tenths = wr_data;
                IDX_SEC_U:  state_d.sec_u  = wr_data;
                IDX_SEC_T:  state_d.sec_t  = wr_data;
                IDX_MIN_U:  state_d.min_u  = wr_data;
                IDX_MIN_T:  state_d.min_t  = wr_data;
                IDX_HR_U:   state_d.hr_u   = wr_data;
                IDX_HR_T:   state_d.hr_t   = wr_data;
                IDX_DAY_U:  state_d.day_u  = wr_data;
                IDX_DAY_T:  state_d.day_t  = wr_data;
                IDX_DOW:    state_d.dow    = wr_data;
                IDX_MON_U:  state_d.mon_u  = wr_data;
                IDX_MON_T:  state_d.mon_t  = wr_data;
                IDX_LEAP:   state_d.leap   = wr_data[LP_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q.day_u  <= 4'd1;
            state_q.mon_u  <= 4'd1;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [3:0] addr,
    input logic [3:0] wr_data,
    input logic [3:0] rd_data,
    input cal_state_t st
);
    a_r3_tenths_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st.tenths < 4'd9) |=> (st.tenths == $past(st.tenths) + 4'd1));

    a_r3_tenths_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st.tenths >= 4'd9) |=> (st.tenths == 4'd0));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(st));

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == IDX_TENTHS) |=> (st.tenths == $past(wr_data)));

    a_r9_dow_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && st.dow != $past(st.dow)) |->
        (st.dow == (($past(st.dow) >= DOW_LAST) ? 4'd0 : $past(st.dow) + 4'd1)));

    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > IDX_LEAP) |-> (rd_data == 4'd0));

    a_r12_leap_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == IDX_LEAP) |-> (rd_data[3:2] == 2'b00));
endmodule

bind bcd_calendar_clock cal_clock_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .st      (state_q)
);

// File: tb/sim_bcd_calendar_clock.sv
module sim_bcd_calendar_clock;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state
    int m_ten, m_s, m_mi, m_h, m_d, m_mo, m_dw, m_ph;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar_clock u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic int mlen(int mo, int ph);
        if (mo == 2) return (ph == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_ten = 0; m_s = 0; m_mi = 0; m_h = 0;
        m_d = 1; m_mo = 1; m_dw = 0; m_ph = 0;
    endtask

    task automatic model_tick();
        m_ten++;
        if (m_ten == 10) begin
            m_ten = 0; m_s++;
            if (m_s == 60) begin
                m_s = 0; m_mi++;
                if (m_mi == 60) begin
                    m_mi = 0; m_h++;
                    if (m_h == 24) begin
                        m_h = 0;
                        m_dw = (m_dw + 1) % 7;
                        if (m_d == mlen(m_mo, m_ph)) begin
                            m_d = 1; m_mo++;
                            if (m_mo == 13) begin
                                m_mo = 1;
                                m_ph = (m_ph + 1) % 4;
                            end
                        end else m_d++;
                    end
                end
            end
        end
    endtask

    task automatic model_write(int a, int v);
        case (a)
            0:  m_ten = v;
            1:  m_s  = (m_s / 10) * 10 + v;
            2:  m_s  = (m_s % 10) + v * 10;
            3:  m_mi = (m_mi / 10) * 10 + v;
            4:  m_mi = (m_mi % 10) + v * 10;
            5:  m_h  = (m_h / 10) * 10 + v;
            6:  m_h  = (m_h % 10) + v * 10;
            7:  m_d  = (m_d / 10) * 10 + v;
            8:  m_d  = (m_d % 10) + v * 10;
            9:  m_dw = v;
            10: m_mo = (m_mo / 10) * 10 + v;
            11: m_mo = (m_mo % 10) + v * 10;
            12: m_ph = v % 4;
            default: ;
        endcase
    endtask

    function automatic int model_read(int a);
        case (a)
            0:  return m_ten;
            1:  return m_s % 10;
            2:  return m_s / 10;
            3:  return m_mi % 10;
            4:  return m_mi / 10;
            5:  return m_h % 10;
            6:  return m_h / 10;
            7:  return m_d % 10;
            8:  return m_d / 10;
            9:  return m_dw;
            10: return m_mo % 10;
            11: return m_mo / 10;
            12: return m_ph;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp, int a);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s index %0d actual %0d expected %0d", tag, a, act, exp);
        end
    endtask

    // Drive one cycle (inputs set at a falling edge), then check at the next falling edge.
    task automatic step(bit tk, bit we, int a, int d, string tag);
        tick = tk; wr_en = we; addr = 4'(a); wr_data = 4'(d);
        if (tk) model_tick();
        if (we) model_write(a, d);
        @(negedge clk);
        check(tag, int'(rd_data), model_read(a), a);
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 16; i++) step(0, 0, i, 0, tag);
    endtask

    task automatic set_all(int ten, int s, int mi, int h, int d, int mo, int dw, int ph);
        step(0, 1, 0,  ten,     "R2");
        step(0, 1, 1,  s % 10,  "R2");
        step(0, 1, 2,  s / 10,  "R2");
        step(0, 1, 3,  mi % 10, "R2");
        step(0, 1, 4,  mi / 10, "R2");
        step(0, 1, 5,  h % 10,  "R2");
        step(0, 1, 6,  h / 10,  "R2");
        step(0, 1, 7,  d % 10,  "R2");
        step(0, 1, 8,  d / 10,  "R2");
        step(0, 1, 9,  dw,      "R2");
        step(0, 1, 10, mo % 10, "R2");
        step(0, 1, 11, mo / 10, "R2");
        step(0, 1, 12, ph,      "R12");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R11 unused indices read zero
        read_all("R1");

        // R3/R4: free-running ticks across a minute boundary
        for (int k = 0; k < 700; k++) step(1, 0, k % 5, 0, "R4");
        // R3: hold with no tick
        for (int k = 0; k < 20; k++) step(0, 0, k % 13, 0, "R3");

        // R5: hour units into tens, then 23 -> 00 into the day
        set_all(9, 59, 59, 9, 15, 3, 2, 1);
        step(1, 0, 6, 0, "R5");
        read_all("R5");
        set_all(9, 59, 59, 23, 15, 3, 2, 1);
        step(1, 0, 7, 0, "R5");
        read_all("R5");

        // R6: 30-day and 31-day month ends
        set_all(9, 59, 59, 23, 30, 4, 3, 1);
        step(1, 0, 10, 0, "R6");
        read_all("R6");
        set_all(9, 59, 59, 23, 31, 1, 3, 1);
        step(1, 0, 11, 0, "R6");
        read_all("R6");
        set_all(9, 59, 59, 23, 30, 1, 3, 1);
        step(1, 0, 8, 0, "R6");
        read_all("R6");

        // R7: February in leap phase 0, then the 29th rolls to March
        set_all(9, 59, 59, 23, 28, 2, 1, 0);
        step(1, 0, 7, 0, "R7");
        read_all("R7");
        set_all(9, 59, 59, 23, 29, 2, 1, 0);
        step(1, 0, 10, 0, "R7");
        read_all("R7");
        // R7: phase 1, the 28th rolls to March
        set_all(9, 59, 59, 23, 28, 2, 1, 1);
        step(1, 0, 10, 0, "R7");
        read_all("R7");

        // R8/R9: year boundary with dow 6 -> 0 and phase 3 -> 0
        set_all(9, 59, 59, 23, 31, 12, 6, 3);
        step(1, 0, 12, 0, "R8");
        read_all("R8");
        step(0, 0, 9, 0, "R9");
        // R8: months 09 -> 10 carry into tens digit
        set_all(9, 59, 59, 23, 30, 9, 4, 2);
        step(1, 0, 11, 0, "R8");
        read_all("R8");

        // R10: write to tenths while it wraps; the carry still reaches seconds
        set_all(9, 0, 0, 0, 5, 5, 0, 1);
        step(1, 1, 0, 5, "R10");
        read_all("R10");
        // R10: write to seconds units while a carry enters it
        set_all(9, 8, 0, 0, 5, 5, 0, 1);
        step(1, 1, 1, 3, "R10");
        read_all("R10");

        // R11: writes to unused indices change nothing
        step(0, 1, 13, 15, "R11");
        step(0, 1, 14, 7,  "R11");
        step(0, 1, 15, 9,  "R11");
        read_all("R11");

        // R12: only two phase bits are stored
        step(0, 1, 12, 14, "R12");
        step(0, 0, 12, 0,  "R12");
        step(0, 1, 12, 7,  "R12");
        step(0, 0, 12, 0,  "R12");

        tick = 0; wr_en = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule